// File: doc/BRIEF.md
# Saturating Page Write-Cycle Counter Bank

This block keeps a small bank of write-cycle counters. Each counter belongs to one of the upper pages of a paged memory. Whenever a copy into memory completes, the memory controller pulses a strobe and gives the page number. If that page has a counter, the counter advances by one. Each copy to a counted page therefore leaves a new count behind, and a transaction can be audited by that count. The counters cannot be written from the bus. They start at zero on reset. They stop at their maximum value and never wrap back to a small number.

A read access that walks to the end of a counted page calls the readout port. The port takes a snapshot of that page's counter. It then delivers the snapshot as bytes, one byte per cycle, least significant byte first. All counter values are also present on a flat output vector for local logic.

With the default parameters there are four 32-bit counters on pages 12 to 15 of a 16-page memory. The first counted page, the number of counters and the counter width are all parameters.

Top module: `pwc_counter_bank`

## Requirements
- R1: After a synchronous reset every counter reads zero, and `rd_valid` and `rd_last` are low.
- R2: A `copy_done` pulse with `copy_page` equal to FIRST_PAGE+i increments counter i by exactly one. The new value appears on `cnt_flat[i*CNT_W +: CNT_W]` in the cycle after the pulse. With the defaults, page 12 maps to i=0 and page 15 maps to i=3.
- R3: A `copy_done` pulse naming a page outside FIRST_PAGE to FIRST_PAGE+NUM_CNT-1 (pages 0 to 11 by default) changes no counter.
- R4: A counter that has reached all ones stays at all ones on further copies to its page. It never rolls over.
- R5: While `copy_done` is low, no counter changes, whatever value `copy_page` has.
- R6: A `rd_req` pulse naming a counted page starts a readout. In the cycle after the request, `rd_valid` rises for exactly CNT_W/8 consecutive cycles. `rd_byte` carries byte k of the counter in the k-th cycle, starting with bits 7:0. Bit 0 of each byte is the first bit to go out on the serial bus. `rd_last` is high only in the final byte cycle.
- R7: The bytes read out are the counter value as it stood just before the request edge. Copies to the same page during the readout do not alter the bytes, but they are still counted.
- R8: A `rd_req` naming a page without a counter produces no `rd_valid`.
- R9: A `rd_req` that arrives while a readout is in progress is ignored. The current readout is not disturbed, and no second readout follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| copy_done | input | 1 | One-cycle strobe: a copy into memory has completed |
| copy_page | input | PAGE_W (4) | Page that received the copy |
| rd_req | input | 1 | One-cycle strobe: start counter readout for `rd_page` |
| rd_page | input | PAGE_W (4) | Page whose counter is to be read |
| cnt_flat | output | NUM_CNT*CNT_W (128) | All counter values, counter i in bits i*CNT_W upward |
| rd_valid | output | 1 | `rd_byte` holds a readout byte |
| rd_byte | output | 8 | Current readout byte |
| rd_last | output | 1 | Final byte of the readout |

## Verification
A copy strobe sampled at a rising edge shows up in `cnt_flat` directly after that edge, so its result is due one cycle later. A readout request sampled at an edge puts byte 0 on the port after that same edge, and byte k follows k cycles later. The bench drives inputs on falling edges and compares outputs on the next falling edge. Each check therefore lands exactly one register stage after its stimulus. Readout bytes are checked on successive falling edges, so every byte is tied to its own cycle and the first idle cycle after `rd_last` is also checked.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pwc_page_sel.sv
module pwc_page_sel #(
  parameter int PAGE_W     = 4,
  parameter int NUM_CNT    = 4,
  parameter int FIRST_PAGE = 12
) (
  input  logic [PAGE_W-1:0]  page,
  output logic [NUM_CNT-1:0] sel,
  output logic               hit
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cmp
    assign sel[i] = (page == PAGE_W'(FIRST_PAGE + i));
  end

  assign hit = |sel;

  // R3: at most one counter may be addressed by any page number
  always_comb begin
    a_r3_sel_onehot: assert ($onehot0(sel));
  end
endmodule

// File: rtl/pwc_sat_counter.sv
module pwc_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (inc && (cnt != MAX_VAL))
      cnt <= cnt + 1'b1;
  end

  a_r4_hold_at_max: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAX_VAL) |=> (cnt == MAX_VAL));

  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    (inc && (cnt != MAX_VAL)) |=> (cnt == $past(cnt) + 1'b1));

  a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/pwc_readout.sv
module pwc_readout
  import pwc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] value,
  output logic             rd_valid,
  output byte_t            rd_byte,
  output logic             rd_last
);
  localparam int NBYTES = CNT_W / BYTE_W;
  localparam int IDX_W  = idx_width(NBYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

  logic [CNT_W-1:0] snap;
  logic [IDX_W-1:0] idx;
  logic             busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      snap <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        snap <= value;
      end
    end else begin
      snap <= snap >> BYTE_W;
      idx  <= idx + 1'b1;
      if (idx == LAST_IDX)
        busy <= 1'b0;
    end
  end

  assign rd_valid = busy;
  assign rd_byte  = snap[BYTE_W-1:0];
  assign rd_last  = busy && (idx == LAST_IDX);

  // R6: readout ends right after its last byte
  a_r6_last_then_idle: assert property (@(posedge clk) disable iff (rst)
    rd_last |=> !rd_valid);

  // R6: bytes stream back to back until the last one
  a_r6_no_gap: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_last) |=> rd_valid);

  // R9: a request during a readout does not restart it
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_last && start) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/pwc_counter_bank.sv
module pwc_counter_bank
  import pwc_pkg::*;
#(
  parameter int PAGE_W     = 4,
  parameter int NUM_CNT    = 4,
  parameter int FIRST_PAGE = 12,
  parameter int CNT_W      = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     copy_done,
  input  logic [PAGE_W-1:0]        copy_page,
  input  logic                     rd_req,
  input  logic [PAGE_W-1:0]        rd_page,
  output logic [NUM_CNT*CNT_W-1:0] cnt_flat,
  output logic                     rd_valid,
  output logic [BYTE_W-1:0]        rd_byte,
  output logic                     rd_last
);
  logic [NUM_CNT-1:0] copy_sel;
  logic               copy_hit;
  logic [NUM_CNT-1:0] rd_sel;
  logic               rd_hit;
  logic [CNT_W-1:0]   rd_value;

  pwc_page_sel #(
    .PAGE_W(PAGE_W), .NUM_CNT(NUM_CNT), .FIRST_PAGE(FIRST_PAGE)
  ) i_copy_sel (
    .page(copy_page), .sel(copy_sel), .hit(copy_hit)
  );

  pwc_page_sel #(
    .PAGE_W(PAGE_W), .NUM_CNT(NUM_CNT), .FIRST_PAGE(FIRST_PAGE)
  ) i_rd_sel (
    .page(rd_page), .sel(rd_sel), .hit(rd_hit)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pwc_sat_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk),
      .rst(rst),
      .inc(copy_done && copy_sel[i]),
      .cnt(cnt_flat[i*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    rd_value = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (rd_sel[i])
        rd_value = rd_value | cnt_flat[i*CNT_W +: CNT_W];
  end

  pwc_readout #(.CNT_W(CNT_W)) i_readout (
    .clk(clk),
    .rst(rst),
    .start(rd_req && rd_hit),
    .value(rd_value),
    .rd_valid(rd_valid),
    .rd_byte(rd_byte),
    .rd_last(rd_last)
  );

  // R3: a copy outside the counted pages leaves every counter as it was
  a_r3_uncounted_page: assert property (@(posedge clk) disable iff (rst)
    (copy_done && !copy_hit) |=> $stable(cnt_flat));

  // R8: a request for a page without a counter starts nothing
  a_r8_no_start: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid && rd_req && !rd_hit) |=> !rd_valid);
endmodule

// File: tb/test_pwc_counter_bank.sv
`timescale 1ns/1ps
module test_pwc_counter_bank;
  localparam int CNT_W  = 32;
  localparam int NCNT   = 4;
  localparam int S_W    = 16;
  localparam int NVEC   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic             copy_done = 1'b0;
  logic [3:0]       copy_page = '0;
  logic             rd_req = 1'b0;
  logic [3:0]       rd_page = '0;
  logic [NCNT*CNT_W-1:0] cnt_flat;
  logic             rd_valid;
  logic [7:0]       rd_byte;
  logic             rd_last;

  logic             s_copy_done = 1'b0;
  logic [3:0]       s_copy_page = '0;
  logic             s_rd_req = 1'b0;
  logic [3:0]       s_rd_page = '0;
  logic [NCNT*S_W-1:0] s_cnt_flat;
  logic             s_rd_valid;
  logic [7:0]       s_rd_byte;
  logic             s_rd_last;

  pwc_counter_bank i_pwc_counter_bank (
    .clk(clk), .rst(rst),
    .copy_done(copy_done), .copy_page(copy_page),
    .rd_req(rd_req), .rd_page(rd_page),
    .cnt_flat(cnt_flat), .rd_valid(rd_valid),
    .rd_byte(rd_byte), .rd_last(rd_last)
  );

  pwc_counter_bank #(.CNT_W(S_W)) i_sat (
    .clk(clk), .rst(rst),
    .copy_done(s_copy_done), .copy_page(s_copy_page),
    .rd_req(s_rd_req), .rd_page(s_rd_page),
    .cnt_flat(s_cnt_flat), .rd_valid(s_rd_valid),
    .rd_byte(s_rd_byte), .rd_last(s_rd_last)
  );

  // vector: {copy page, expected counter index (4 = none)}
  localparam logic [7:0] VEC [NVEC] = '{
    {4'd12, 4'd0}, {4'd13, 4'd1}, {4'd12, 4'd0}, {4'd3,  4'd4},
    {4'd15, 4'd3}, {4'd14, 4'd2}, {4'd0,  4'd4}, {4'd11, 4'd4},
    {4'd15, 4'd3}, {4'd12, 4'd0}, {4'd13, 4'd1}, {4'd7,  4'd4}
  };

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] model [NCNT];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NCNT; i++)
      check(req, cnt_flat[i*CNT_W +: CNT_W], model[i]);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCNT; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_all("R1");
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R1 rd_last", {31'd0, rd_last}, 32'd0);
    check("R1 sat bank", {16'd0, s_cnt_flat[15:0]}, 32'd0);

    // R5: page moves while strobe is low
    copy_page = 4'd12;
    @(negedge clk);
    copy_page = 4'd15;
    @(negedge clk);
    check_all("R5");

    // R2 / R3: table walk
    for (int v = 0; v < NVEC; v++) begin
      copy_done = 1'b1;
      copy_page = VEC[v][7:4];
      @(negedge clk);
      copy_done = 1'b0;
      if (VEC[v][3:0] < 4'd4) model[VEC[v][3:0]]++;
      check_all((VEC[v][3:0] < 4'd4) ? "R2" : "R3");
    end

    // R8: request for a page without a counter
    rd_req = 1'b1;
    rd_page = 4'd5;
    @(negedge clk);
    rd_req = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check("R8", {31'd0, rd_valid}, 32'd0);
      @(negedge clk);
    end

    // bring counter 1 (page 13) to 300 = 0x12C
    copy_done = 1'b1;
    copy_page = 4'd13;
    repeat (298) @(negedge clk);
    copy_done = 1'b0;
    model[1] = model[1] + 298;
    check("R2 run", cnt_flat[1*CNT_W +: CNT_W], 32'd300);

    // R6 / R7 / R9: readout of page 13 with copies and a second request
    rd_req = 1'b1;
    rd_page = 4'd13;
    @(negedge clk);
    rd_req = 1'b0;
    copy_done = 1'b1;
    copy_page = 4'd13;
    check("R6 valid0", {31'd0, rd_valid}, 32'd1);
    check("R6 byte0", {24'd0, rd_byte}, 32'h2C);
    check("R6 last0", {31'd0, rd_last}, 32'd0);
    @(negedge clk);
    rd_req = 1'b1;
    rd_page = 4'd12;
    check("R7 byte1", {24'd0, rd_byte}, 32'h01);
    @(negedge clk);
    rd_req = 1'b0;
    copy_done = 1'b0;
    check("R7 byte2", {24'd0, rd_byte}, 32'h00);
    check("R9 valid2", {31'd0, rd_valid}, 32'd1);
    @(negedge clk);
    check("R6 byte3", {24'd0, rd_byte}, 32'h00);
    check("R6 last3", {31'd0, rd_last}, 32'd1);
    @(negedge clk);
    check("R9 idle after", {31'd0, rd_valid}, 32'd0);
    model[1] = model[1] + 2;
    check_all("R7 counted");
    @(negedge clk);
    check("R9 no second", {31'd0, rd_valid}, 32'd0);

    // R4: saturation on the narrow bank, page 15
    s_copy_done = 1'b1;
    s_copy_page = 4'd15;
    repeat (65540) @(negedge clk);
    s_copy_done = 1'b0;
    check("R4 max", {16'd0, s_cnt_flat[3*S_W +: S_W]}, 32'hFFFF);
    check("R3 others", {16'd0, s_cnt_flat[0 +: S_W]}, 32'd0);
    s_copy_done = 1'b1;
    @(negedge clk);
    s_copy_done = 1'b0;
    check("R4 hold", {16'd0, s_cnt_flat[3*S_W +: S_W]}, 32'hFFFF);
    s_rd_req = 1'b1;
    s_rd_page = 4'd15;
    @(negedge clk);
    s_rd_req = 1'b0;
    check("R6 sat b0", {24'd0, s_rd_byte}, 32'hFF);
    check("R6 sat last0", {31'd0, s_rd_last}, 32'd0);
    @(negedge clk);
    check("R6 sat b1", {24'd0, s_rd_byte}, 32'hFF);
    check("R6 sat last1", {31'd0, s_rd_last}, 32'd1);
    @(negedge clk);
    check("R6 sat idle", {31'd0, s_rd_valid}, 32'd0);

    // R1: reset again clears counts
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NCNT; i++) model[i] = '0;
    check_all("R1 rerun");
    check("R1 sat rerun", {16'd0, s_cnt_flat[3*S_W +: S_W]}, 32'd0);

    finish_run();
  end
endmodule